// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritizer

This block folds the interrupt-causing conditions of a serial port into one interrupt line and an 8-bit identification value that host software reads to learn why it was interrupted. Four categories are tracked: receive line errors, received data (a level above the trigger point, or a stale-data timeout), transmit holding register empty, and modem status change. Each category is gated by its own enable bit. When several categories want attention at once, only the most urgent is named in the identification value. The rest stay latched and are named once the more urgent ones have been serviced.

Edge-type conditions (line error, timeout, holding-empty, modem change) arrive as one-cycle event pulses and are held in sticky flags. Each flag is cleared by the host access that services it: a line status read, a data read, a holding register write or an identification read while holding-empty is the reported cause, or a modem status read. The received-data-available condition is a level driven by the receive FIFO and is not latched here. All outputs are combinational from the flags, the enables, the data level and the FIFO-mode indication.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with FIFO mode off and no events, `iir` reads 0x01 and `irq` is low.
- R2: `iir[0]` is 0 exactly when some enabled cause is pending, and `irq` is its inverse.
- R3: A line-error event latches a cause reported as code 3'b011 in `iir[3:1]`. It outranks every other cause and is cleared by `rd_lsr`.
- R4: While `rx_avail` is high and no line error is pending, code 3'b010 is reported, including when a timeout is also pending.
- R5: A timeout event latches a cause reported as 3'b110 when no line error is pending and `rx_avail` is low. It is cleared by `rd_rbr`.
- R6: A holding-empty event latches a cause reported as 3'b001 below the receive causes. A `wr_thr` strobe clears it.
- R7: An `rd_iir` strobe clears the holding-empty cause only when 3'b001 is the code being reported. An `rd_iir` strobe while a higher cause is reported leaves it pending.
- R8: A modem-change event latches the lowest cause, code 3'b000 with `iir[0]`=0. It is cleared by `rd_msr`.
- R9: Enable bits map as `ier[0]` for received data and timeout, `ier[1]` for holding-empty, `ier[2]` for line error, and `ier[3]` for modem change. A disabled cause is neither reported nor drives `irq`, but stays latched and is reported once it is enabled.
- R10: `iir[7:6]` both equal `fifo_en`, and `iir[5:4]` are always 0.
- R11: When an event and its clearing strobe arrive in the same cycle, the cause stays pending.
- R12: An event pulse shows in `iir` only after the clock edge that samples it. Changes to the enables, `rx_avail` and `fifo_en` show in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier | input | 4 | Per-category interrupt enables |
| fifo_en | input | 1 | FIFO mode indication |
| line_err_evt | input | 1 | Pulse: receive line error or break detected |
| rx_avail | input | 1 | Level: receive data at or above the trigger point |
| rx_tmo_evt | input | 1 | Pulse: receive stale-data timeout |
| thr_empty_evt | input | 1 | Pulse: transmit holding register became empty |
| msr_chg_evt | input | 1 | Pulse: a modem status line changed |
| rd_iir | input | 1 | Host read of the identification value |
| rd_lsr | input | 1 | Host read of line status |
| rd_rbr | input | 1 | Host read of receive data |
| rd_msr | input | 1 | Host read of modem status |
| wr_thr | input | 1 | Host write of the transmit holding register |
| iir | output | 8 | Identification value |
| irq | output | 1 | Interrupt request, active high |

## Verification
Event pulses and host strobes reach the outputs one edge later. The bench drives each one on a falling edge, removes it on the next falling edge, and samples there, which is one rising edge after the strobe. To show that nothing moves earlier, the bench also samples 1 ns after driving an event. Enables, `rx_avail` and `fifo_en` take effect without a register, so the bench samples them 1 ns after the drive.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_CAT   = 4;
  localparam int unsigned NUM_STICK = 4;
  localparam int unsigned ID_W      = 8;
  localparam int unsigned CODE_W    = 3;

  // sticky flag slots
  localparam int unsigned S_LINE = 0;
  localparam int unsigned S_TMO  = 1;
  localparam int unsigned S_THR  = 2;
  localparam int unsigned S_MSR  = 3;

  // enable bit positions
  localparam int unsigned E_RX   = 0;
  localparam int unsigned E_THR  = 1;
  localparam int unsigned E_LINE = 2;
  localparam int unsigned E_MSR  = 3;

  typedef enum logic [CODE_W-1:0] {
    ID_MSR  = 3'b000,
    ID_THR  = 3'b001,
    ID_RXD  = 3'b010,
    ID_LINE = 3'b011,
    ID_TMO  = 3'b110
  } irq_id_e;
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R11
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o); // R3
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NUM_CAT-1:0] en_i,
  input  logic               line_i,
  input  logic               rxd_i,
  input  logic               tmo_i,
  input  logic               thr_i,
  input  logic               msr_i,
  output irq_id_e            code_o,
  output logic               pend_o
);
  logic line_q, rxd_q, tmo_q, thr_q, msr_q;

  always_comb begin
    line_q = line_i & en_i[E_LINE];
    rxd_q  = rxd_i  & en_i[E_RX];
    tmo_q  = tmo_i  & en_i[E_RX];
    thr_q  = thr_i  & en_i[E_THR];
    msr_q  = msr_i  & en_i[E_MSR];
    pend_o = line_q | rxd_q | tmo_q | thr_q | msr_q;
    if (line_q)      code_o = ID_LINE;
    else if (rxd_q)  code_o = ID_RXD;
    else if (tmo_q)  code_o = ID_TMO;
    else if (thr_q)  code_o = ID_THR;
    else             code_o = ID_MSR;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CAT-1:0] ier,
  input  logic               fifo_en,
  input  logic               line_err_evt,
  input  logic               rx_avail,
  input  logic               rx_tmo_evt,
  input  logic               thr_empty_evt,
  input  logic               msr_chg_evt,
  input  logic               rd_iir,
  input  logic               rd_lsr,
  input  logic               rd_rbr,
  input  logic               rd_msr,
  input  logic               wr_thr,
  output logic [ID_W-1:0]    iir,
  output logic               irq
);
  logic [NUM_STICK-1:0] set_v, clr_v, flag_v;
  irq_id_e              code;
  logic                 pend;
  logic                 thr_reported;

  assign thr_reported = pend && (code == ID_THR);

  always_comb begin
    set_v         = '0;
    clr_v         = '0;
    set_v[S_LINE] = line_err_evt;
    set_v[S_TMO]  = rx_tmo_evt;
    set_v[S_THR]  = thr_empty_evt;
    set_v[S_MSR]  = msr_chg_evt;
    clr_v[S_LINE] = rd_lsr;
    clr_v[S_TMO]  = rd_rbr;
    clr_v[S_THR]  = wr_thr | (rd_iir & thr_reported);
    clr_v[S_MSR]  = rd_msr;
  end

  for (genvar g = 0; g < NUM_STICK; g++) begin : g_flag
    uart_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .flag_o (flag_v[g])
    );
  end

  uart_irq_prio u_prio (
    .en_i   (ier),
    .line_i (flag_v[S_LINE]),
    .rxd_i  (rx_avail),
    .tmo_i  (flag_v[S_TMO]),
    .thr_i  (flag_v[S_THR]),
    .msr_i  (flag_v[S_MSR]),
    .code_o (code),
    .pend_o (pend)
  );

  always_comb begin
    iir = {fifo_en, fifo_en, 2'b00, code, ~pend};
    irq = pend;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    iir[5:4] == 2'b00); // R10
  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_v[S_LINE] && ier[E_LINE]) |-> (iir[3:0] == 4'b0110)); // R3
  AST_THR_IIR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && !iir[0] && iir[3:1] == ID_THR && !thr_empty_evt) |=> !flag_v[S_THR]); // R7
  AST_THR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_v[S_THR] && !wr_thr && !(rd_iir && thr_reported)) |=> flag_v[S_THR]); // R7
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (iir[3:0] == 4'b0001)); // R2
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] ier = '0;
  logic fifo_en = 1'b0, line_err_evt = 1'b0, rx_avail = 1'b0, rx_tmo_evt = 1'b0;
  logic thr_empty_evt = 1'b0, msr_chg_evt = 1'b0;
  logic rd_iir = 1'b0, rd_lsr = 1'b0, rd_rbr = 1'b0, rd_msr = 1'b0, wr_thr = 1'b0;
  logic [7:0] iir;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .ier(ier), .fifo_en(fifo_en),
    .line_err_evt(line_err_evt), .rx_avail(rx_avail), .rx_tmo_evt(rx_tmo_evt),
    .thr_empty_evt(thr_empty_evt), .msr_chg_evt(msr_chg_evt),
    .rd_iir(rd_iir), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_msr(rd_msr),
    .wr_thr(wr_thr), .iir(iir), .irq(irq)
  );

  // irq must always be the inverse of the expected bit 0 (R2)
  task automatic chk(input string req, input logic [7:0] exp);
    n_chk++;
    if (iir !== exp || irq !== ~exp[0]) begin
      n_bad++;
      $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b", req, iir, irq, exp, ~exp[0]);
    end
  endtask

  // which: 0 line,1 tmo,2 thr,3 msr,4 rd_iir,5 rd_lsr,6 rd_rbr,7 rd_msr,8 wr_thr
  task automatic drv(input int which, input logic v);
    case (which)
      0: line_err_evt = v;  1: rx_tmo_evt = v;  2: thr_empty_evt = v;
      3: msr_chg_evt = v;   4: rd_iir = v;      5: rd_lsr = v;
      6: rd_rbr = v;        7: rd_msr = v;      default: wr_thr = v;
    endcase
  endtask

  task automatic pulse(input int which);
    @(negedge clk); drv(which, 1'b1);
    @(negedge clk); drv(which, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 reset", 8'h01);
    fifo_en = 1'b1; #1 chk("R10 fifo bits", 8'hC1);
    fifo_en = 1'b0; #1 chk("R10 fifo off", 8'h01);
  endtask

  task automatic t_line;
    ier = 4'hF;
    @(negedge clk); line_err_evt = 1'b1;
    #1 chk("R12 no early change", 8'h01);
    @(negedge clk); line_err_evt = 1'b0;
    chk("R3 line reported", 8'h06);
    pulse(3); chk("R3 line outranks modem", 8'h06);
    pulse(5); chk("R8 modem after line cleared", 8'h00);
    pulse(7); chk("R8 modem cleared", 8'h01);
  endtask

  task automatic t_rx;
    rx_avail = 1'b1; #1 chk("R12 R4 data level immediate", 8'h04);
    pulse(1); chk("R4 data over timeout", 8'h04);
    rx_avail = 1'b0; #1 chk("R5 timeout reported", 8'h0C);
    pulse(6); chk("R5 timeout cleared", 8'h01);
  endtask

  task automatic t_thr;
    pulse(2); chk("R6 thr reported", 8'h02);
    pulse(0); chk("R3 line over thr", 8'h06);
    pulse(4); chk("R7 iir read with line shown", 8'h06);
    pulse(5); chk("R7 thr survived", 8'h02);
    pulse(4); chk("R7 iir read clears thr", 8'h01);
    pulse(2); pulse(8); chk("R6 write clears thr", 8'h01);
  endtask

  task automatic t_mask;
    ier = 4'h0;
    pulse(3); chk("R9 disabled modem hidden", 8'h01);
    ier = 4'b1000; #1 chk("R9 enabled later", 8'h00);
    ier = 4'b0111; pulse(0); ier = 4'b1000; #1 chk("R9 masked line lets modem", 8'h00);
    ier = 4'hF; pulse(5); pulse(7); chk("R9 cleared", 8'h01);
  endtask

  task automatic t_race;
    @(negedge clk); line_err_evt = 1'b1; rd_lsr = 1'b1;
    @(negedge clk); line_err_evt = 1'b0; rd_lsr = 1'b0;
    chk("R11 set wins", 8'h06);
    pulse(5); chk("R11 then cleared", 8'h01);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_line();
    t_rx();
    t_thr();
    t_mask();
    t_race();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule